// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This unit conditions the second operand of an ALU. One 32-bit word goes in with a shift kind, a shift distance and the current carry flag. The unit returns the shifted or rotated word and the carry the operation produces. Every kind sets the carry to the last bit that leaves the word. The rotate-through-carry kind feeds the incoming carry into the top bit. The shift distance comes either from a 5-bit immediate field or from the low 8 bits of a register value.

Operations arrive on a valid/ready stream and results leave on another one. A transfer happens on a rising clock edge when valid and ready are both high. With `REG_OUT = 1` (the default), the result is held in a single output register. `in_ready` is high when that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and carry stay frozen and no new operation is taken in. With `REG_OUT = 0` the path is purely combinational: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. The distance is an unsigned count, written n below, and W is the data width (32).

Top module: `bshift_unit`

## Requirements
- R1: Kind code 0 (shift left) moves bits toward the MSB and fills vacated low bits with zero. The carry is the last bit pushed out of the top. For n = W the result is zero and the carry is bit 0; for n > W the result and the carry are zero.
- R2: Kind code 1 (logical right) moves bits toward the LSB and fills vacated high bits with zero. The carry is the last bit pushed out of the bottom. For n = W the result is zero and the carry is bit W-1; for n > W the result and the carry are zero.
- R3: Kind code 2 (arithmetic right) moves bits toward the LSB and fills vacated high bits with the original sign bit. The carry is the last bit pushed out of the bottom. For n >= W every result bit and the carry equal the sign bit.
- R4: Kind code 3 (rotate right) wraps bits leaving the LSB back in at the MSB, using n modulo W. The carry equals the last bit rotated out, which is the new MSB. A nonzero multiple of W returns the operand unchanged with the carry equal to bit W-1.
- R5: Kind code 4 (rotate through carry) always moves by exactly one place and ignores n. The incoming carry becomes the new MSB, and the old LSB becomes the carry.
- R6: For kind codes 0 to 3 with n = 0, the operand is returned unchanged and the incoming carry is returned as the carry.
- R7: When `in_amt_src` is 0, n is the zero-extended `in_imm`. When it is 1, n is bits 7:0 of `in_reg_amt`, and all higher bits of that value are ignored.
- R8: Kind codes 5 to 7 return the operand and the incoming carry unchanged.
- R9: With the output register, a result appears on `out_valid` in the cycle after its operation is accepted. It stays stable while `out_ready` is low. In that case `in_ready` is low, and a held input is taken in the same edge at which the stalled result drains.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take the offered operation |
| in_data | input | 32 | Operand to shift |
| in_kind | input | 3 | Shift kind code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry) |
| in_amt_src | input | 1 | Distance source: 0 immediate, 1 register |
| in_imm | input | 5 | Immediate distance |
| in_reg_amt | input | 32 | Register value whose low 8 bits give the distance |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry |

## Verification
The in-design properties sample the combinational result only in cycles where `in_valid` is high. They assume that the operand, kind, distance fields and carry are driven to known values whenever an operation is offered. The stall property assumes the consumer never lowers `out_ready` as a way to cancel a result. The bench drives every field at the falling edge before raising `in_valid` and keeps all fields constant while an operation is held. For each case it computes the expected word and carry by stepping the operand one bit position at a time.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [2:0] {
    K_LSL = 3'd0,
    K_LSR = 3'd1,
    K_ASR = 3'd2,
    K_ROR = 3'd3,
    K_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/bshift_amt_sel.sv
module bshift_amt_sel #(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  parameter int IMM_W = 5
) (
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic [W-1:0]     reg_val,
  output logic [AMT_W-1:0] amt
);
  // register distances use only the low AMT_W bits
  always_comb begin
    if (use_reg) amt = reg_val[AMT_W-1:0];
    else         amt = {{(AMT_W-IMM_W){1'b0}}, imm};
  end

  logic unused_hi;
  assign unused_hi = ^reg_val[W-1:AMT_W];
endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     op,
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amt,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cy
);
  localparam int IDX_W = $clog2(W);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

  // one spare bit beside the word catches the last bit shifted out
  logic        [W:0]     lsl_ext;
  logic        [W:0]     lsr_ext;
  logic signed [W:0]     asr_ext;
  logic        [IDX_W-1:0] rot;
  logic        [W-1:0]   ror_w;
  logic                  amt_zero, amt_lt, amt_eq;

  assign amt_zero = (amt == '0);
  assign amt_lt   = (amt < W_AMT);
  assign amt_eq   = (amt == W_AMT);
  assign lsl_ext  = {1'b0, op} << amt;
  assign lsr_ext  = {op, 1'b0} >> amt;
  assign asr_ext  = $signed({op, 1'b0}) >>> amt;
  assign rot      = amt[IDX_W-1:0];
  assign ror_w    = (op >> rot) | (op << (W - int'(rot)));

  always_comb begin
    res = op;
    cy  = cin;
    unique case (kind)
      K_LSL: begin
        if (amt_zero)    begin res = op;                cy = cin;          end
        else if (amt_lt) begin res = lsl_ext[W-1:0];    cy = lsl_ext[W];   end
        else if (amt_eq) begin res = '0;                cy = op[0];        end
        else             begin res = '0;                cy = 1'b0;         end
      end
      K_LSR: begin
        if (amt_zero)    begin res = op;                cy = cin;          end
        else if (amt_lt) begin res = lsr_ext[W:1];      cy = lsr_ext[0];   end
        else if (amt_eq) begin res = '0;                cy = op[W-1];      end
        else             begin res = '0;                cy = 1'b0;         end
      end
      K_ASR: begin
        if (amt_zero)    begin res = op;                cy = cin;          end
        else if (amt_lt) begin res = asr_ext[W:1];      cy = asr_ext[0];   end
        else             begin res = {W{op[W-1]}};      cy = op[W-1];      end
      end
      K_ROR: begin
        if (amt_zero)        begin res = op;    cy = cin;          end
        else if (rot == '0)  begin res = op;    cy = op[W-1];      end
        else                 begin res = ror_w; cy = ror_w[W-1];   end
      end
      K_RRX: begin
        res = {cin, op[W-1:1]};
        cy  = op[0];
      end
      default: begin
        res = op;
        cy  = cin;
      end
    endcase
  end
endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
  parameter int PW      = 33,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [PW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [PW-1:0] dn_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic          full_q;
      logic [PW-1:0] data_q;

      assign up_ready = !full_q || dn_ready;
      assign dn_valid = full_q;
      assign dn_data  = data_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else if (up_ready) begin
          full_q <= up_valid;
          if (up_valid) data_q <= up_data;
        end
      end

      AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data))); // R9
      AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |-> !up_ready); // R9
    end else begin : g_comb
      assign up_ready = dn_ready;
      assign dn_valid = up_valid;
      assign dn_data  = up_data;
    end
  endgenerate
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         in_data,
  input  logic [2:0]           in_kind,
  input  logic                 in_amt_src,
  input  logic [$clog2(W)-1:0] in_imm,
  input  logic [W-1:0]         in_reg_amt,
  input  logic                 in_carry,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_data,
  output logic                 out_carry
);
  localparam int IMM_W = $clog2(W);
  localparam int PW    = W + 1;

  logic [AMT_W-1:0] amt_w;
  logic [W-1:0]     core_res;
  logic             core_cy;
  logic [PW-1:0]    stage_out;

  bshift_amt_sel #(.W(W), .AMT_W(AMT_W), .IMM_W(IMM_W)) amt_i (
    .use_reg (in_amt_src),
    .imm     (in_imm),
    .reg_val (in_reg_amt),
    .amt     (amt_w)
  );

  bshift_core #(.W(W), .AMT_W(AMT_W)) core_i (
    .op   (in_data),
    .kind (shift_kind_e'(in_kind)),
    .amt  (amt_w),
    .cin  (in_carry),
    .res  (core_res),
    .cy   (core_cy)
  );

  bshift_stage #(.PW(PW), .REG_OUT(REG_OUT)) stage_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  ({core_cy, core_res}),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (stage_out)
  );

  assign out_carry = stage_out[W];
  assign out_data  = stage_out[W-1:0];

  AST_LSL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd0 && amt_w != '0) |-> (core_res[0] == 1'b0)); // R1
  AST_ASR_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd2) |-> (core_res[W-1] == in_data[W-1])); // R3
  AST_RRX_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd4) |-> (core_res[W-1] == in_carry && core_cy == in_data[0])); // R5
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind < 3'd4 && amt_w == '0) |-> (core_res == in_data && core_cy == in_carry)); // R6
  AST_ODD_KIND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind > 3'd4) |-> (core_res == in_data && core_cy == in_carry)); // R8
endmodule

// File: tb/bshift_unit_tb_top.sv
module bshift_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [2:0]  in_kind = '0;
  logic        in_amt_src = 1'b0;
  logic [4:0]  in_imm = '0;
  logic [31:0] in_reg_amt = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_carry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bshift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_kind(in_kind), .in_amt_src(in_amt_src),
    .in_imm(in_imm), .in_reg_amt(in_reg_amt), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_carry(out_carry)
  );

  task automatic chk(input string tag, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // step model: move the word one place per step, remembering the bit that leaves
  function automatic logic [32:0] model(input logic [31:0] op, input logic [2:0] kind,
                                        input int n, input logic cin);
    logic [31:0] r = op;
    logic        c = cin;
    case (kind)
      3'd0: for (int i = 0; i < n; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
      3'd1: for (int i = 0; i < n; i++) begin c = r[0];  r = {1'b0, r[31:1]}; end
      3'd2: for (int i = 0; i < n; i++) begin c = r[0];  r = {op[31], r[31:1]}; end
      3'd3: for (int i = 0; i < n; i++) begin c = r[0];  r = {r[0], r[31:1]}; end
      3'd4: begin c = op[0]; r = {cin, op[31:1]}; end
      default: ;
    endcase
    return {c, r};
  endfunction

  task automatic run_op(input string tag, input logic [31:0] op, input logic [2:0] kind,
                        input logic src, input logic [4:0] imm, input logic [31:0] regv,
                        input logic cin);
    int n;
    n = src ? int'(regv[7:0]) : int'(imm);
    @(negedge clk);
    in_data = op; in_kind = kind; in_amt_src = src; in_imm = imm;
    in_reg_amt = regv; in_carry = cin; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {32'd0, out_valid}, 33'd1);
    chk(tag, {out_carry, out_data}, model(op, kind, n, cin));
  endtask

  task automatic t_reset;
    chk("R10 out_valid", {32'd0, out_valid}, 33'd0);
    chk("R10 in_ready", {32'd0, in_ready}, 33'd1);
  endtask

  task automatic t_left;
    run_op("R1 lsl 1", 32'h8000_0003, 3'd0, 1'b0, 5'd1, '0, 1'b0);
    run_op("R1 lsl 31", 32'h0000_0003, 3'd0, 1'b0, 5'd31, '0, 1'b0);
    run_op("R1 lsl 32", 32'h0000_0001, 3'd0, 1'b1, '0, 32'd32, 1'b0);
    run_op("R1 lsl 33", 32'hFFFF_FFFF, 3'd0, 1'b1, '0, 32'd33, 1'b1);
  endtask

  task automatic t_right;
    run_op("R2 lsr 4", 32'hF000_0018, 3'd1, 1'b0, 5'd4, '0, 1'b0);
    run_op("R2 lsr 32", 32'h8000_0000, 3'd1, 1'b1, '0, 32'd32, 1'b0);
    run_op("R2 lsr 40", 32'hFFFF_FFFF, 3'd1, 1'b1, '0, 32'd40, 1'b1);
    run_op("R3 asr neg 3", 32'h8000_0004, 3'd2, 1'b0, 5'd3, '0, 1'b0);
    run_op("R3 asr pos 5", 32'h4000_0010, 3'd2, 1'b0, 5'd5, '0, 1'b1);
    run_op("R3 asr neg 32", 32'h8000_0000, 3'd2, 1'b1, '0, 32'd32, 1'b0);
    run_op("R3 asr pos 200", 32'h7FFF_FFFF, 3'd2, 1'b1, '0, 32'd200, 1'b1);
  endtask

  task automatic t_rotate;
    run_op("R4 ror 8", 32'h1234_5681, 3'd3, 1'b0, 5'd8, '0, 1'b0);
    run_op("R4 ror 32", 32'h8000_0001, 3'd3, 1'b1, '0, 32'd32, 1'b0);
    run_op("R4 ror 64", 32'h7000_0001, 3'd3, 1'b1, '0, 32'd64, 1'b1);
    run_op("R4 ror 36", 32'h0000_00F8, 3'd3, 1'b1, '0, 32'd36, 1'b0);
    run_op("R5 rrx cin1", 32'h0000_0002, 3'd4, 1'b0, 5'd0, '0, 1'b1);
    run_op("R5 rrx cin0 amt ignored", 32'hFFFF_FFFF, 3'd4, 1'b0, 5'd17, '0, 1'b0);
  endtask

  task automatic t_zero_and_codes;
    for (int k = 0; k < 4; k++) begin
      run_op("R6 zero amount", 32'hA5A5_0F0F, 3'(k), 1'b0, 5'd0, '0, 1'b1);
      run_op("R6 zero reg amount", 32'h5A5A_F0F0, 3'(k), 1'b1, '0, 32'hFFFF_FF00, 1'b0);
    end
    for (int k = 5; k < 8; k++)
      run_op("R8 spare code", 32'hDEAD_BEEF, 3'(k), 1'b0, 5'd9, '0, 1'b1);
    run_op("R7 high reg bits ignored", 32'h0000_0F00, 3'd1, 1'b1, 5'd0, 32'hABCD_EF04, 1'b0);
    run_op("R7 imm used not reg", 32'h0000_0F00, 3'd1, 1'b0, 5'd2, 32'd8, 1'b0);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 5; k++)
      for (int n = 0; n <= 40; n++) begin
        run_op("R1 R2 R3 R4 R5 sweep", 32'h8000_0001 ^ (32'h0101_0101 << k), 3'(k),
               1'b1, '0, 32'(n), n[0]);
        run_op("R1 R2 R3 R4 R5 sweep b", 32'h7F3C_A5E1, 3'(k), 1'b1, '0, 32'(n), ~n[0]);
      end
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_data = 32'h0000_00F0; in_kind = 3'd0; in_amt_src = 1'b0; in_imm = 5'd4;
    in_carry = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    chk("R9 first result", {out_carry, out_data}, model(32'h0000_00F0, 3'd0, 4, 1'b0));
    chk("R9 in_ready low when stalled", {32'd0, in_ready}, 33'd0);
    in_data = 32'h0000_0F00; in_kind = 3'd1; in_imm = 5'd8;
    @(negedge clk);
    chk("R9 result held", {out_carry, out_data}, model(32'h0000_00F0, 3'd0, 4, 1'b0));
    chk("R9 valid held", {32'd0, out_valid}, 33'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second result", {out_carry, out_data}, model(32'h0000_0F00, 3'd1, 8, 1'b0));
    @(negedge clk);
    chk("R9 drained", {32'd0, out_valid}, 33'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left();
    t_right();
    t_rotate();
    t_zero_and_codes();
    t_sweep();
    t_stall();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule